// File: doc/BRIEF.md
# Paired Floating-Point Register File

This block holds the floating-point register state of a processor core: thirty-two 32-bit registers, indices 0 to 31. The same storage can also be seen as sixteen 64-bit registers. Each 64-bit register is made from an even/odd pair and is named by its even index. Inside a pair the even register carries the upper 32 bits and the odd register carries the lower 32 bits. When a 64-bit value is later stored to memory, the even word goes to the lower address and the odd word goes to the address 4 above it.

There are two combinational read ports and one synchronous write port. Every port has a 5-bit register index and a width select (0 = single, 32 bits; 1 = double, 64 bits). A single read places the register in the low half of the 64-bit result and zero in the upper half. A double access with an odd index is misaligned. It raises a flag, a misaligned read returns zero, and a misaligned write changes nothing.

Top module: `fprf_top`

## Requirements
- R1: An active-high synchronous reset clears all 32 registers to zero, so every aligned read returns zero after reset.
- R2: A single write (w_dbl=0) with w_en=1 stores w_data[31:0] into register w_idx at the rising edge. A single read returns {32'h0, reg[idx]}.
- R3: A single write leaves the other register of its even/odd pair unchanged.
- R4: A double write (w_dbl=1, even w_idx) with w_en=1 updates both registers in the same edge: reg[w_idx] gets w_data[63:32] and reg[w_idx+1] gets w_data[31:0].
- R5: A double read with an even index returns {reg[idx], reg[idx+1]}.
- R6: When w_en=1, w_dbl=1 and w_idx is odd, w_misalign is 1 and no register changes. In every other case w_misalign is 0.
- R7: A double read with an odd index drives its misalign output to 1 and its data to zero. Every other read drives its misalign output to 0.
- R8: A read of a register that is being written in the same cycle returns the contents held before the write. There is no bypass.
- R9: With w_en=0, no register changes.
- R10: The two read ports work independently and can read different registers, in different widths, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 5 | Read port A register index |
| ra_dbl | input | 1 | Read port A width select (1 = 64-bit pair) |
| ra_data | output | 64 | Read port A data |
| ra_misalign | output | 1 | Read port A odd-index double access |
| rb_idx | input | 5 | Read port B register index |
| rb_dbl | input | 1 | Read port B width select (1 = 64-bit pair) |
| rb_data | output | 64 | Read port B data |
| rb_misalign | output | 1 | Read port B odd-index double access |
| w_en | input | 1 | Write enable |
| w_idx | input | 5 | Write register index |
| w_dbl | input | 1 | Write width select (1 = 64-bit pair) |
| w_data | input | 64 | Write data (single uses bits 31:0) |
| w_misalign | output | 1 | Write is an odd-index double and is dropped |

## Verification
The bench first runs directed patterns. The first writes a single register and then reads its pair partner; this shows a correct single write apart from one that disturbs the whole pair. The second writes a double and reads back both halves individually; this catches a swapped word order. The third is an odd-index double write; it shows whether the write is really suppressed or leaks into a neighbour. The fourth reads a register in the same cycle that register is written; it tells an old-value read apart from a bypass. A long random mix of widths, indices, enables and concurrent reads on both ports then exercises the ports against an independent model of the register contents.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  parameter int unsigned NREG = 32;
  parameter int unsigned WORD = 32;
  localparam int unsigned IDXW  = $clog2(NREG);
  localparam int unsigned DWORD = 2 * WORD;

  // odd index with a 64-bit access cannot name a pair
  function automatic logic odd_pair(input logic dbl, input logic [IDXW-1:0] idx);
    return dbl & idx[0];
  endfunction

  // even register is the upper word of a pair
  function automatic logic [DWORD-1:0] join_pair(input logic [WORD-1:0] hi,
                                                 input logic [WORD-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD-1:0] hi_word(input logic [DWORD-1:0] d);
    return d[DWORD-1:WORD];
  endfunction

  function automatic logic [WORD-1:0] lo_word(input logic [DWORD-1:0] d);
    return d[WORD-1:0];
  endfunction
endpackage

// File: rtl/fprf_write_ctrl.sv
module fprf_write_ctrl
  import fprf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       w_en,
  input  logic [IDXW-1:0]            w_idx,
  input  logic                       w_dbl,
  input  logic [DWORD-1:0]           w_data,
  output logic [NREG-1:0]            we,
  output logic [NREG-1:0][WORD-1:0]  wd,
  output logic                       misalign
);
  logic bad;
  assign bad      = odd_pair(w_dbl, w_idx);
  assign misalign = w_en & bad;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g % 2 == 0) begin : g_even
      assign we[g] = w_en && !bad && (w_idx == IDXW'(g));
      assign wd[g] = w_dbl ? hi_word(w_data) : lo_word(w_data);
    end else begin : g_odd
      assign we[g] = w_en && !bad &&
                     ((!w_dbl && w_idx == IDXW'(g)) || (w_dbl && w_idx == IDXW'(g - 1)));
      assign wd[g] = lo_word(w_data);
    end
  end

  // R6
  misalign_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (we == '0));
  // R3
  single_one_reg_chk: assert property (@(posedge clk) disable iff (rst)
    !w_dbl |-> $onehot0(we));
  // R4
  double_two_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (w_en && w_dbl && !bad) |-> ($countones(we) == 2));
endmodule

// File: rtl/fprf_bank.sv
module fprf_bank
  import fprf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREG-1:0]            we,
  input  logic [NREG-1:0][WORD-1:0]  wd,
  output logic [NREG-1:0][WORD-1:0]  regs
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)        regs[i] <= '0;
      else if (we[i]) regs[i] <= wd[i];
    end
  end

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (!rst && rst_q) begin
      reset_clear_chk: assert (regs == '0);
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we == '0) |=> $stable(regs));
endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
  import fprf_pkg::*;
(
  input  logic [NREG-1:0][WORD-1:0]  regs,
  input  logic [IDXW-1:0]            idx,
  input  logic                       dbl,
  output logic [DWORD-1:0]           data,
  output logic                       misalign
);
  logic [IDXW-1:0] ev_idx;
  logic [IDXW-1:0] od_idx;
  assign ev_idx   = {idx[IDXW-1:1], 1'b0};
  assign od_idx   = {idx[IDXW-1:1], 1'b1};
  assign misalign = odd_pair(dbl, idx);

  always_comb begin
    if (misalign)  data = '0;
    else if (dbl)  data = join_pair(regs[ev_idx], regs[od_idx]);
    else           data = join_pair('0, regs[idx]);
  end
endmodule

// File: rtl/fprf_top.sv
module fprf_top
  import fprf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDXW-1:0]   ra_idx,
  input  logic              ra_dbl,
  output logic [DWORD-1:0]  ra_data,
  output logic              ra_misalign,
  input  logic [IDXW-1:0]   rb_idx,
  input  logic              rb_dbl,
  output logic [DWORD-1:0]  rb_data,
  output logic              rb_misalign,
  input  logic              w_en,
  input  logic [IDXW-1:0]   w_idx,
  input  logic              w_dbl,
  input  logic [DWORD-1:0]  w_data,
  output logic              w_misalign
);
  logic [NREG-1:0]           wr_sel;
  logic [NREG-1:0][WORD-1:0] wr_word;
  logic [NREG-1:0][WORD-1:0] store;

  fprf_write_ctrl u_wc (
    .clk(clk), .rst(rst), .w_en(w_en), .w_idx(w_idx), .w_dbl(w_dbl),
    .w_data(w_data), .we(wr_sel), .wd(wr_word), .misalign(w_misalign)
  );

  fprf_bank u_bank (
    .clk(clk), .rst(rst), .we(wr_sel), .wd(wr_word), .regs(store)
  );

  fprf_read_port u_rpa (
    .regs(store), .idx(ra_idx), .dbl(ra_dbl), .data(ra_data), .misalign(ra_misalign)
  );

  fprf_read_port u_rpb (
    .regs(store), .idx(rb_idx), .dbl(rb_dbl), .data(rb_data), .misalign(rb_misalign)
  );

  // R5
  double_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (w_en && w_dbl && !w_idx[0]) |=>
      (!(ra_dbl && ra_idx == $past(w_idx)) || ra_data == $past(w_data)));
  // R2
  single_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (w_en && !w_dbl) |=>
      (!(!ra_dbl && ra_idx == $past(w_idx)) ||
       ra_data == {{WORD{1'b0}}, $past(w_data[WORD-1:0])}));
  // R7
  read_misalign_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rb_dbl && rb_idx[0]) |-> (rb_misalign && rb_data == '0));
endmodule

// File: tb/fprf_top_test.sv
module fprf_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ra_idx = '0, rb_idx = '0, w_idx = '0;
  logic        ra_dbl = 1'b0, rb_dbl = 1'b0, w_dbl = 1'b0, w_en = 1'b0;
  logic [63:0] ra_data, rb_data, w_data = '0;
  logic        ra_misalign, rb_misalign, w_misalign;

  always #5 clk = ~clk;

  fprf_top uut (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_dbl(ra_dbl), .ra_data(ra_data), .ra_misalign(ra_misalign),
    .rb_idx(rb_idx), .rb_dbl(rb_dbl), .rb_data(rb_data), .rb_misalign(rb_misalign),
    .w_en(w_en), .w_idx(w_idx), .w_dbl(w_dbl), .w_data(w_data), .w_misalign(w_misalign)
  );

  logic [31:0] m [32];
  int checks = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [63:0] exp_rd(input logic [4:0] i, input logic d);
    if (d && i[0]) return 64'h0;
    if (d)         return {m[i], m[i + 5'd1]};
    return {32'h0, m[i]};
  endfunction

  function automatic string rd_tag(input logic [4:0] i, input logic d);
    if (d && i[0]) return "R7";
    if (d)         return "R5";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, check combinational outputs, then update model at the edge
  task automatic step(input logic [4:0] ai, input logic ad, input logic [4:0] bi,
                      input logic bd, input logic we, input logic [4:0] wi,
                      input logic wdb, input logic [63:0] wdat, input string tag);
    @(negedge clk);
    ra_idx = ai; ra_dbl = ad; rb_idx = bi; rb_dbl = bd;
    w_en = we; w_idx = wi; w_dbl = wdb; w_data = wdat;
    #1;
    chk(tag != "" ? tag : rd_tag(ai, ad), ra_data, exp_rd(ai, ad));
    chk(tag != "" ? tag : "R10", rb_data, exp_rd(bi, bd));
    chk("R7", {63'h0, ra_misalign}, {63'h0, ad & ai[0]});
    chk("R7", {63'h0, rb_misalign}, {63'h0, bd & bi[0]});
    chk("R6", {63'h0, w_misalign}, {63'h0, we & wdb & wi[0]});
    @(posedge clk);
    if (we && !(wdb && wi[0])) begin
      if (wdb) begin
        m[wi] = wdat[63:32];
        m[wi + 5'd1] = wdat[31:0];
      end else begin
        m[wi] = wdat[31:0];
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < 32; i++) m[i] = '0;
    seed = $urandom(32'd551);
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i += 2)
      step(5'(i), 1'b0, 5'(i + 1), 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R1");

    // R2/R3: single write to 5, partner 4 untouched
    step(5'd4, 1'b0, 5'd5, 1'b0, 1'b1, 5'd4, 1'b0, 64'h0000_0000_1111_2222, "");
    step(5'd4, 1'b0, 5'd5, 1'b0, 1'b1, 5'd5, 1'b0, 64'hdead_beef_3333_4444, "R2");
    step(5'd4, 1'b0, 5'd5, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R3");
    step(5'd4, 1'b1, 5'd5, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R3");

    // R4: double write to pair 6/7, read halves singly and as a pair
    step(5'd6, 1'b0, 5'd7, 1'b0, 1'b1, 5'd6, 1'b1, 64'hAAAA_0001_BBBB_0002, "");
    step(5'd6, 1'b0, 5'd7, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R4");
    step(5'd6, 1'b1, 5'd6, 1'b1, 1'b0, 5'd0, 1'b0, 64'h0, "R5");

    // R6: misaligned double write at 7 changes nothing
    step(5'd6, 1'b0, 5'd8, 1'b0, 1'b1, 5'd7, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "");
    step(5'd6, 1'b1, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 64'h0, "R6");
    step(5'd7, 1'b0, 5'd8, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R6");

    // R7: misaligned reads on both ports
    step(5'd7, 1'b1, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 64'h0, "R7");

    // R8: same-cycle read of the written register sees old value, then new
    step(5'd10, 1'b0, 5'd10, 1'b1, 1'b1, 5'd10, 1'b1, 64'h1234_5678_9ABC_DEF0, "R8");
    step(5'd10, 1'b1, 5'd11, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R8");

    // R9: enable low with data and index applied
    step(5'd12, 1'b1, 5'd13, 1'b0, 1'b0, 5'd12, 1'b1, 64'h5555_5555_5555_5555, "");
    step(5'd12, 1'b1, 5'd13, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0, "R9");

    // R10 and random mix of widths, indices and enables
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] ai, bi, wi;
      logic ad, bd, we, wdb;
      logic [63:0] wdat;
      ai = 5'($urandom % 32); bi = 5'($urandom % 32); wi = 5'($urandom % 32);
      ad = 1'($urandom % 2);  bd = 1'($urandom % 2);
      we = ($urandom % 4) != 0; wdb = 1'($urandom % 2);
      wdat = {$urandom, $urandom};
      step(ai, ad, bi, bd, we, wi, wdb, wdat, "");
    end

    finish_run();
  end
endmodule